// File: doc/BRIEF.md
# Q32.32 Fourth-Order Recursive Bandpass Filter

This block filters a stream of unsigned 10-bit converter samples with a fourth-order recursive bandpass section. It computes entirely in signed Q32.32: 64-bit words with 32 integer bits above 32 fraction bits. Each accepted sample goes into the integer half of a Q32.32 word. It is then scaled by a fixed gain of about 0.0976 and pushed into a short history of scaled inputs. A sparse recurrence combines that history with the history of past outputs through two fixed negative feedback coefficients.

Every product is a full signed 64x64 multiply. The multiplier builds it from signed upper halves and unsigned lower halves, so a value such as -0.5 is handled as one two's-complement number. Only bits 95..32 of the 128-bit product are kept. The filter was designed for a 400 kHz sample rate with its passband centred at 100 kHz.

A sample is offered with a one-cycle strobe. The result appears with its own one-cycle strobe a fixed number of cycles later. Strobes that arrive while a result is being computed are dropped.

Top module: `iir_bandpass_q32`

## Requirements
- R1: An accepted sample s is widened to the Q32.32 word s*2^32 and multiplied by the gain 0x0000000018FE59A0. The result becomes the newest scaled input x[n]. After reset, a single sample of 1 therefore gives the output 0x0000000018FE59A0.
- R2: Every product is the signed two's-complement product of two Q32.32 words, truncated to bits 95..32 of the 128-bit result.
- R3: The output is y[n] = x[n] + x[n-4] - 2*x[n-2] + c1*y[n-4] + c2*y[n-2]. The doubling is a one-place left shift.
- R4: The feedback coefficients are c1 = 0xFFFFFFFFAAAAAA80 (about -0.3333) and c2 = 0xFFFFFFFF0EA41100 (about -0.9428).
- R5: All additions and subtractions wrap modulo 2^64, with no saturation.
- R6: A sample is accepted on a rising edge where valid_i is high and no computation is in flight. valid_o is high for exactly one cycle, starting three rising edges after the accepting edge.
- R7: A valid_i strobe seen during the two cycles after an acceptance is ignored and leaves both histories unchanged.
- R8: Reset (rst_ni low) clears both histories, y_o and valid_o to zero.
- R9: y_o holds its value between valid_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | 10 | Unsigned converter sample |
| valid_o | output | 1 | One-cycle result strobe |
| y_o | output | 64 | Filter output, signed Q32.32 |

## Verification
The assertions check the handshake on every cycle. They cover the fixed latency from acceptance to valid_o, the one-cycle width of that pulse, the busy window that follows each acceptance, and that y_o holds still between pulses. Arithmetic correctness is shown only by the bench. It compares each output with a 128-bit reference of the same recurrence while driving an impulse, a step, a table of mixed samples, random samples, dropped strobes and a reset in the middle of a stream.

// File: rtl/iirq_pkg.sv
package iirq_pkg;
  localparam int unsigned W      = 64;
  localparam int unsigned FRAC   = 32;
  localparam int unsigned SMP_W  = 10;
  localparam int unsigned ORDER  = 4;

  localparam logic [W-1:0] GAIN_Q = 64'h0000_0000_18FE_59A0;
  localparam logic [W-1:0] C1_Q   = 64'hFFFF_FFFF_AAAA_AA80;
  localparam logic [W-1:0] C2_Q   = 64'hFFFF_FFFF_0EA4_1100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_SUM  = 2'd2
  } iirq_state_e;
endpackage

// File: rtl/iirq_frac_mul.sv
// signed W x W -> bits [W+FRAC-1:FRAC] of full product, built from half-width partials
module iirq_frac_mul #(
  parameter int unsigned W    = 64,
  parameter int unsigned FRAC = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned PW = 2 * W;

  logic signed [2*H:0]   a_hi_x, b_hi_x, a_lo_x, b_lo_x;
  logic signed [2*H:0]   pp_ah_bl, pp_bh_al;
  logic signed [2*H-1:0] pp_hh;
  logic        [2*H-1:0] pp_ll;
  logic signed [PW-1:0]  t_hh, t_ahbl, t_bhal, t_ll, full;

  // upper halves signed, lower halves unsigned
  assign a_hi_x = {{(H+1){a_i[W-1]}}, a_i[W-1:H]};
  assign b_hi_x = {{(H+1){b_i[W-1]}}, b_i[W-1:H]};
  assign a_lo_x = {{(H+1){1'b0}}, a_i[H-1:0]};
  assign b_lo_x = {{(H+1){1'b0}}, b_i[H-1:0]};

  assign pp_hh    = a_hi_x[2*H-1:0] * b_hi_x[2*H-1:0];
  assign pp_ll    = a_i[H-1:0] * b_i[H-1:0];
  assign pp_ah_bl = a_hi_x * b_lo_x;
  assign pp_bh_al = b_hi_x * a_lo_x;

  always_comb begin
    t_hh   = {pp_hh, {W{1'b0}}};
    t_ahbl = {{(PW-2*H-1-H){pp_ah_bl[2*H]}}, pp_ah_bl, {H{1'b0}}};
    t_bhal = {{(PW-2*H-1-H){pp_bh_al[2*H]}}, pp_bh_al, {H{1'b0}}};
    t_ll   = {{(PW-2*H){1'b0}}, pp_ll};
    full   = t_hh + t_ahbl + t_bhal + t_ll;
  end

  assign p_o = full[W+FRAC-1:FRAC];
endmodule

// File: rtl/iirq_delay_line.sv
module iirq_delay_line #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      shift_i,
  input  logic [W-1:0]              din_i,
  output logic [DEPTH-1:0][W-1:0]   taps_o
);
  // taps_o[0] newest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      taps_o[0] <= '0;
    else if (shift_i) taps_o[0] <= din_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      taps_o[k] <= '0;
      else if (shift_i) taps_o[k] <= taps_o[k-1];
    end
  end
endmodule

// File: rtl/iirq_ctrl.sv
module iirq_ctrl
  import iirq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic accept_o,
  output logic mul_en_o,
  output logic sum_en_o,
  output logic busy_o
);
  iirq_state_e st_q, st_d;

  assign accept_o = valid_i && (st_q == ST_IDLE);
  assign mul_en_o = (st_q == ST_MUL);
  assign sum_en_o = (st_q == ST_SUM);
  assign busy_o   = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (valid_i) st_d = ST_MUL;
      ST_MUL:  st_d = ST_SUM;
      ST_SUM:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/iir_bandpass_q32.sv
module iir_bandpass_q32
  import iirq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] sample_i,
  output logic             valid_o,
  output logic [W-1:0]     y_o
);
  localparam int unsigned XD   = ORDER + 1;
  localparam int unsigned YD   = ORDER;
  localparam int unsigned HALF = ORDER / 2;
  localparam int unsigned PADW = W - FRAC - SMP_W;

  logic accept, mul_en, sum_en, busy;
  logic [SMP_W-1:0] samp_q;
  logic [W-1:0] widened, x_new, fb_far, fb_near, fb_far_q, fb_near_q, y_new;
  logic [XD-1:0][W-1:0] x_taps;
  logic [YD-1:0][W-1:0] y_taps;

  iirq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .accept_o (accept),
    .mul_en_o (mul_en),
    .sum_en_o (sum_en),
    .busy_o   (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= '0;
    else if (accept) samp_q <= sample_i;
  end

  assign widened = {{PADW{1'b0}}, samp_q, {FRAC{1'b0}}};

  iirq_frac_mul #(.W(W), .FRAC(FRAC)) u_mul_gain (
    .a_i (widened), .b_i (GAIN_Q), .p_o (x_new)
  );
  // y taps: index k holds y[n-1-k]
  iirq_frac_mul #(.W(W), .FRAC(FRAC)) u_mul_far (
    .a_i (C1_Q), .b_i (y_taps[ORDER-1]), .p_o (fb_far)
  );
  iirq_frac_mul #(.W(W), .FRAC(FRAC)) u_mul_near (
    .a_i (C2_Q), .b_i (y_taps[HALF-1]), .p_o (fb_near)
  );

  iirq_delay_line #(.W(W), .DEPTH(XD)) u_xhist (
    .clk_i (clk_i), .rst_ni (rst_ni), .shift_i (mul_en),
    .din_i (x_new), .taps_o (x_taps)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_far_q  <= '0;
      fb_near_q <= '0;
    end else if (mul_en) begin
      fb_far_q  <= fb_far;
      fb_near_q <= fb_near;
    end
  end

  // 64-bit wrapping sum
  assign y_new = x_taps[0] + x_taps[ORDER] - (x_taps[HALF] << 1)
               + fb_far_q + fb_near_q;

  iirq_delay_line #(.W(W), .DEPTH(YD)) u_yhist (
    .clk_i (clk_i), .rst_ni (rst_ni), .shift_i (sum_en),
    .din_i (y_new), .taps_o (y_taps)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= sum_en;
      if (sum_en) y_o <= y_new;
    end
  end
endmodule

// File: rtl/iir_bandpass_q32_chk.sv
module iir_bandpass_q32_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        busy,
  input logic        valid_o,
  input logic [63:0] y_o
);
  a_r6_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i && !busy, 3));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !busy) |=> busy);

  a_r7_idle_at_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy);

  a_r9_hold_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> (valid_o || $stable(y_o)));
endmodule

bind iir_bandpass_q32 iir_bandpass_q32_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .busy    (busy),
  .valid_o (valid_o),
  .y_o     (y_o)
);

// File: tb/iir_bandpass_q32_tb_top.sv
`timescale 1ns/1ps
module iir_bandpass_q32_tb_top;
  localparam logic [63:0] GAIN = 64'h0000_0000_18FE_59A0;
  localparam logic [63:0] C1   = 64'hFFFF_FFFF_AAAA_AA80;
  localparam logic [63:0] C2   = 64'hFFFF_FFFF_0EA4_1100;
  localparam int NV = 12;
  localparam logic [9:0] STIM [NV] = '{10'd1023, 10'd0, 10'd512, 10'd7,
                                       10'd1023, 10'd1023, 10'd0, 10'd300,
                                       10'd1, 10'd999, 10'd64, 10'd0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [9:0] sample_i = '0;
  logic valid_o;
  logic [63:0] y_o;
  int errors = 0;
  int checks = 0;
  logic [63:0] xm [5];
  logic [63:0] ym [4];
  logic [63:0] exp_y;

  always #4 clk = ~clk;

  iir_bandpass_q32 dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i),
    .sample_i (sample_i), .valid_o (valid_o), .y_o (y_o)
  );

  function automatic logic [63:0] qmul(input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] pa, pb, pr;
    pa = {{64{a[63]}}, a};
    pb = {{64{b[63]}}, b};
    pr = pa * pb;
    return pr[95:32];
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 5; k++) xm[k] = '0;
    for (int k = 0; k < 4; k++) ym[k] = '0;
  endtask

  task automatic model_step(input logic [9:0] s);
    for (int k = 4; k > 0; k--) xm[k] = xm[k-1];
    xm[0] = qmul({22'd0, s, 32'd0}, GAIN);
    exp_y = xm[0] + xm[4] - (xm[2] << 1) + qmul(C1, ym[3]) + qmul(C2, ym[1]);
    for (int k = 3; k > 0; k--) ym[k] = ym[k-1];
    ym[0] = exp_y;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // drive one sample; optionally hold strobe one extra cycle with junk data
  task automatic send(input logic [9:0] s, input bit extra, input logic [9:0] junk, input string req);
    @(negedge clk); valid_i = 1'b1; sample_i = s;
    @(negedge clk);
    if (extra) begin
      sample_i = junk;
      check("R6 valid_o low while busy", {63'd0, valid_o}, 64'd0);
      @(negedge clk); valid_i = 1'b0;
    end else begin
      valid_i = 1'b0;
      check("R6 valid_o low while busy", {63'd0, valid_o}, 64'd0);
      @(negedge clk);
    end
    check("R6 valid_o low before latency", {63'd0, valid_o}, 64'd0);
    @(negedge clk);
    check("R6 valid_o at latency", {63'd0, valid_o}, 64'd1);
    model_step(s);
    check(req, y_o, exp_y);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    model_reset();
    repeat (3) @(negedge clk);
    check("R8 reset y_o", y_o, 64'd0);
    check("R8 reset valid_o", {63'd0, valid_o}, 64'd0);
    rst_ni = 1'b1;

    // R1: unit impulse, then zeros (impulse response exercises R2, R4)
    send(10'd1, 0, 0, "R1 gain of unit sample");
    check("R1 exact gain word", y_o, GAIN);
    for (int i = 0; i < 10; i++) send(10'd0, 0, 0, "R4 impulse tail");

    // R9: output holds after pulse
    held = y_o;
    repeat (3) @(negedge clk);
    check("R9 hold y_o", y_o, held);
    check("R6 pulse one cycle", {63'd0, valid_o}, 64'd0);

    // step input
    for (int i = 0; i < 12; i++) send(10'd1023, 0, 0, "R3 step response");

    // table walk
    for (int i = 0; i < NV; i++) send(STIM[i], 0, 0, "R3 table vector");

    // R7: extra strobe during busy is dropped
    send(10'd200, 1, 10'd1000, "R7 first of double strobe");
    send(10'd50, 0, 0, "R7 history unaffected");
    send(10'd5, 1, 10'd1023, "R7 second double strobe");
    send(10'd0, 0, 0, "R7 history unaffected again");

    // random, wrap-around arithmetic
    for (int i = 0; i < 60; i++) send(10'($urandom), 0, 0, "R5 random wrap");

    // R8: reset mid-stream clears histories
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R8 mid reset y_o", y_o, 64'd0);
    check("R8 mid reset valid_o", {63'd0, valid_o}, 64'd0);
    rst_ni = 1'b1;
    model_reset();
    send(10'd1, 0, 0, "R8 fresh impulse after reset");
    check("R8 fresh gain word", y_o, GAIN);
    send(10'd0, 0, 0, "R8 clean history");
    send(10'd0, 0, 0, "R2 negative term -2x[n-2]+c2*y[n-2]");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule